// File: doc/BRIEF.md
# Byte-Lane Register Window Adapter

This block connects a byte-addressable host I/O port to register targets that only accept whole 32-bit words. It decodes a 128-byte window into three regions: a bank of core registers, a bank of DMA registers, and a single control register that the adapter holds itself. The rest of the window is unmapped.

A host read fetches the whole target word. It shifts the word down to the addressed byte and masks it to the access width. A host write that is narrower than a word, or that does not start on a word boundary, is widened. The adapter first fetches the target's current word, replaces only the addressed byte lanes, and then issues one aligned full-word write. The core and DMA banks sit outside the block. The adapter drives their word index and reads their current word back combinationally. Every accepted access takes the same fixed number of cycles, whether it is a read, a write, narrow or full.

Top module: `bw_window_adapter`

## Requirements
- R1: After reset `host_ready` is 1, `host_done` is 0 and the control register output `ctrl_q` is 0.
- R2: A request is accepted in a cycle where `host_valid` and `host_ready` are both 1. `host_done` is 1 for exactly one cycle, two cycles after the accepting cycle. `host_ready` is 0 from acceptance through that done cycle.
- R3: Byte offsets 0x00 to 0x3F select core word index `addr[5:2]`. Writes there reach only the core target, through `core_we`/`core_wdata`.
- R4: Byte offsets 0x40 to 0x5F select DMA word index `(addr-0x40)>>2`. Writes there reach only the DMA target.
- R5: Offsets 0x70 to 0x73 address the 32-bit control register, which is visible on `ctrl_q`. A write there updates it at the end of the done cycle.
- R6: Offsets 0x60 to 0x6F and 0x74 to 0x7F are unmapped. Writes there change no register, and reads there return 0.
- R7: `host_size` code 0 means 1 byte, code 1 means 2 bytes, and code 2 or 3 means 4 bytes. Data is little-endian: byte k of `host_wdata` goes to byte lane `(addr&3)+k` of the word.
- R8: On a write, the lanes not addressed keep the value fetched from the target. Exactly one full-word write strobe is issued.
- R9: Write bytes whose lane would be 4 or more are dropped. The access never spills into the next word.
- R10: Read data equals the word shifted right by 8*(addr&3) bits and masked to 8*size bits. All higher bits are 0.
- R11: A read issues no write strobe and leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host request present |
| host_write | input | 1 | 1 for write, 0 for read |
| host_addr | input | 7 | Byte offset in the window |
| host_size | input | 2 | Access size code |
| host_wdata | input | 32 | Write bytes, byte 0 in bits 7:0 |
| host_ready | output | 1 | Adapter idle, request can be accepted |
| host_done | output | 1 | Access completes this cycle |
| host_rdata | output | 32 | Read data, valid with host_done |
| core_idx | output | 4 | Core word index |
| core_rdata | input | 32 | Current core word at core_idx |
| core_we | output | 1 | Core full-word write strobe |
| core_wdata | output | 32 | Merged core write word |
| dma_idx | output | 3 | DMA word index |
| dma_rdata | input | 32 | Current DMA word at dma_idx |
| dma_we | output | 1 | DMA full-word write strobe |
| dma_wdata | output | 32 | Merged DMA write word |
| ctrl_q | output | 32 | Control register contents |

## Verification
The hardest case to reach is a write whose lanes run past the word edge (R9). An example is a 4-byte write at offset 3, where three of the four bytes must vanish and the neighbouring word must stay intact. The bench sweeps every offset in the window with every size code. After each write it reads back both the aligned word and the same narrow slice, so every truncating combination is exercised. The sweep also reaches the word boundaries between regions, and the merge is checked against target words that start from distinct non-zero seeds.

// File: rtl/bw_pkg.sv
package bw_pkg;

  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;

  typedef enum logic [1:0] {
    RG_CORE = 2'd0,
    RG_DMA  = 2'd1,
    RG_CTRL = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  // Number of bytes named by a size code.
  function automatic int size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return WORD_BYTES;
    endcase
  endfunction

  // Byte lanes touched by an access, clipped at the word edge.
  function automatic logic [WORD_BYTES-1:0] lane_enables(input logic [1:0] lane,
                                                         input logic [1:0] code);
    logic [WORD_BYTES-1:0] en;
    int lo;
    int hi;
    lo = int'(lane);
    hi = lo + size_bytes(code);
    for (int b = 0; b < WORD_BYTES; b++) begin
      en[b] = (b >= lo) && (b < hi);
    end
    return en;
  endfunction

  // Put the host bytes into their lanes over the fetched word.
  function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] cur,
                                                   input logic [WORD_W-1:0] wdata,
                                                   input logic [1:0] lane,
                                                   input logic [1:0] code);
    logic [WORD_W-1:0]     placed;
    logic [WORD_W-1:0]     res;
    logic [WORD_BYTES-1:0] en;
    placed = wdata << (8 * int'(lane));
    en     = lane_enables(lane, code);
    for (int b = 0; b < WORD_BYTES; b++) begin
      res[8*b +: 8] = en[b] ? placed[8*b +: 8] : cur[8*b +: 8];
    end
    return res;
  endfunction

  // Align the addressed bytes to bit 0 and clear the rest.
  function automatic logic [WORD_W-1:0] extract_word(input logic [WORD_W-1:0] word,
                                                     input logic [1:0] lane,
                                                     input logic [1:0] code);
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] keep;
    shifted = word >> (8 * int'(lane));
    keep    = '0;
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (b < size_bytes(code)) keep[8*b +: 8] = 8'hFF;
    end
    return shifted & keep;
  endfunction

endpackage

// File: rtl/bw_decode.sv
module bw_decode
  import bw_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int CORE_BYTES = 64,
  parameter int DMA_BASE   = 64,
  parameter int DMA_BYTES  = 32,
  parameter int CTRL_BASE  = 112,
  localparam int CORE_IDX_W = $clog2(CORE_BYTES / WORD_BYTES),
  localparam int DMA_IDX_W  = $clog2(DMA_BYTES / WORD_BYTES)
) (
  input  logic [ADDR_W-1:0]     addr,
  output region_e               region,
  output logic [CORE_IDX_W-1:0] core_idx,
  output logic [DMA_IDX_W-1:0]  dma_idx,
  output logic [1:0]            lane
);

  logic [ADDR_W-1:0] dma_off;
  int                a_int;

  always_comb begin
    a_int    = int'(addr);
    dma_off  = addr - ADDR_W'(DMA_BASE);
    core_idx = addr[CORE_IDX_W+1:2];
    dma_idx  = dma_off[DMA_IDX_W+1:2];
    lane     = addr[1:0];
    if (a_int < CORE_BYTES)
      region = RG_CORE;
    else if (a_int >= DMA_BASE && a_int < DMA_BASE + DMA_BYTES)
      region = RG_DMA;
    else if ((a_int / WORD_BYTES) == (CTRL_BASE / WORD_BYTES))
      region = RG_CTRL;
    else
      region = RG_NONE;
  end

endmodule

// File: rtl/bw_lane_unit.sv
module bw_lane_unit
  import bw_pkg::*;
(
  input  logic [WORD_W-1:0] cur_word,
  input  logic [WORD_W-1:0] host_bytes,
  input  logic [1:0]        lane,
  input  logic [1:0]        size_code,
  output logic [WORD_W-1:0] merged,
  output logic [WORD_W-1:0] extracted
);

  always_comb begin
    merged    = merge_word(cur_word, host_bytes, lane, size_code);
    extracted = extract_word(cur_word, lane, size_code);
  end

endmodule

// File: rtl/bw_window_adapter.sv
module bw_window_adapter
  import bw_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int CORE_BYTES = 64,
  parameter int DMA_BASE   = 64,
  parameter int DMA_BYTES  = 32,
  parameter int CTRL_BASE  = 112,
  localparam int CORE_IDX_W = $clog2(CORE_BYTES / WORD_BYTES),
  localparam int DMA_IDX_W  = $clog2(DMA_BYTES / WORD_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_valid,
  input  logic                  host_write,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [1:0]            host_size,
  input  logic [WORD_W-1:0]     host_wdata,
  output logic                  host_ready,
  output logic                  host_done,
  output logic [WORD_W-1:0]     host_rdata,
  output logic [CORE_IDX_W-1:0] core_idx,
  input  logic [WORD_W-1:0]     core_rdata,
  output logic                  core_we,
  output logic [WORD_W-1:0]     core_wdata,
  output logic [DMA_IDX_W-1:0]  dma_idx,
  input  logic [WORD_W-1:0]     dma_rdata,
  output logic                  dma_we,
  output logic [WORD_W-1:0]     dma_wdata,
  output logic [WORD_W-1:0]     ctrl_q
);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_COMMIT} state_e;

  state_e            state;
  logic              op_write;
  logic [ADDR_W-1:0] op_addr;
  logic [1:0]        op_size;
  logic [WORD_W-1:0] op_wdata;
  logic [WORD_W-1:0] cur_q;

  // Named internal events for the checker.
  logic              accept;
  logic              commit_write;
  logic              ctrl_wr;
  logic              region_none;

  region_e           region;
  logic [1:0]        lane;
  logic [WORD_W-1:0] fetched;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] extracted;

  bw_decode #(
    .ADDR_W(ADDR_W), .CORE_BYTES(CORE_BYTES), .DMA_BASE(DMA_BASE),
    .DMA_BYTES(DMA_BYTES), .CTRL_BASE(CTRL_BASE)
  ) u_decode (
    .addr(op_addr), .region(region), .core_idx(core_idx),
    .dma_idx(dma_idx), .lane(lane)
  );

  bw_lane_unit u_lanes (
    .cur_word(cur_q), .host_bytes(op_wdata), .lane(lane),
    .size_code(op_size), .merged(merged), .extracted(extracted)
  );

  always_comb begin
    case (region)
      RG_CORE: fetched = core_rdata;
      RG_DMA:  fetched = dma_rdata;
      RG_CTRL: fetched = ctrl_q;
      default: fetched = '0;
    endcase
  end

  assign host_ready   = (state == ST_IDLE);
  assign accept       = host_valid && host_ready;
  assign host_done    = (state == ST_COMMIT);
  assign commit_write = host_done && op_write;
  assign region_none  = (region == RG_NONE);
  assign core_we      = commit_write && (region == RG_CORE);
  assign dma_we       = commit_write && (region == RG_DMA);
  assign ctrl_wr      = commit_write && (region == RG_CTRL);
  assign core_wdata   = merged;
  assign dma_wdata    = merged;
  assign host_rdata   = (host_done && !op_write) ? extracted : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_write <= 1'b0;
      op_addr  <= '0;
      op_size  <= '0;
      op_wdata <= '0;
      cur_q    <= '0;
      ctrl_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_write <= host_write;
            op_addr  <= host_addr;
            op_size  <= host_size;
            op_wdata <= host_wdata;
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          cur_q <= fetched;
          state <= ST_COMMIT;
        end
        default: begin
          if (ctrl_wr) ctrl_q <= merged;
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/bw_window_adapter_chk.sv
module bw_window_adapter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        host_ready,
  input logic        host_done,
  input logic [31:0] host_rdata,
  input logic        core_we,
  input logic        dma_we,
  input logic        ctrl_wr,
  input logic        commit_write,
  input logic [31:0] ctrl_q,
  input logic        op_write,
  input logic [1:0]  op_size,
  input logic        region_none
);

  a_r2_done_after_two: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 host_done);

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> !host_ready);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_we, dma_we, ctrl_wr}));

  a_r11_strobe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we || dma_we || ctrl_wr) |-> (host_done && commit_write));

  a_r5_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q));

  a_r10_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_done && !op_write && op_size == 2'd0) |-> (host_rdata[31:8] == 24'h0));

  a_r6_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (host_done && region_none) |-> (!core_we && !dma_we && !ctrl_wr && host_rdata == 32'h0));

endmodule

bind bw_window_adapter bw_window_adapter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .host_ready(host_ready),
  .host_done(host_done), .host_rdata(host_rdata), .core_we(core_we),
  .dma_we(dma_we), .ctrl_wr(ctrl_wr), .commit_write(commit_write),
  .ctrl_q(ctrl_q), .op_write(op_write), .op_size(op_size),
  .region_none(region_none)
);

// File: tb/bw_window_adapter_test.sv
module bw_window_adapter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_write = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready, host_done;
  logic [31:0] host_rdata;
  logic [3:0]  core_idx;
  logic [31:0] core_rdata, core_wdata;
  logic        core_we;
  logic [2:0]  dma_idx;
  logic [31:0] dma_rdata, dma_wdata;
  logic        dma_we;
  logic [31:0] ctrl_q;

  int checks = 0;
  int failures = 0;

  logic [31:0] core_mem [16];
  logic [31:0] dma_mem  [8];
  logic [31:0] exp_core [16];
  logic [31:0] exp_dma  [8];
  logic [31:0] exp_ctrl;

  always #10 clk = ~clk;

  bw_window_adapter uut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
    .core_idx(core_idx), .core_rdata(core_rdata), .core_we(core_we),
    .core_wdata(core_wdata), .dma_idx(dma_idx), .dma_rdata(dma_rdata),
    .dma_we(dma_we), .dma_wdata(dma_wdata), .ctrl_q(ctrl_q)
  );

  function automatic logic [31:0] seed(input int i, input logic [31:0] base);
    return base ^ (32'(i) * 32'h9E3779B1);
  endfunction

  // Target register files modelled in the bench.
  assign core_rdata = core_mem[core_idx];
  assign dma_rdata  = dma_mem[dma_idx];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) core_mem[i] <= seed(i, 32'hA5C3_0F11);
      for (int i = 0; i < 8; i++)  dma_mem[i]  <= seed(i, 32'h5A3C_F0EE);
    end else begin
      if (core_we) core_mem[core_idx] <= core_wdata;
      if (dma_we)  dma_mem[dma_idx]   <= dma_wdata;
    end
  end

  function automatic string tag_of(input int a);
    if (a < 64) return "R3";
    if (a < 96) return "R4";
    if (a >= 112 && a < 116) return "R5";
    return "R6";
  endfunction

  function automatic int nbytes(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] model_word(input int a);
    if (a < 64) return exp_core[a / 4];
    if (a >= 64 && a < 96) return exp_dma[(a - 64) / 4];
    if (a >= 112 && a < 116) return exp_ctrl;
    return 32'h0;
  endfunction

  function automatic logic [31:0] model_read(input int a, input int code);
    logic [31:0] w;
    logic [31:0] r;
    w = model_word(a);
    r = 32'h0;
    for (int k = 0; k < nbytes(code); k++) begin
      if ((a % 4) + k < 4) r[8*k +: 8] = w[8*((a % 4) + k) +: 8];
    end
    return r;
  endfunction

  task automatic model_write(input int a, input int code, input logic [31:0] d);
    logic [31:0] w;
    w = model_word(a);
    for (int k = 0; k < nbytes(code); k++) begin
      if ((a % 4) + k < 4) w[8*((a % 4) + k) +: 8] = d[8*k +: 8];
    end
    if (a < 64) exp_core[a / 4] = w;
    else if (a < 96) exp_dma[(a - 64) / 4] = w;
    else if (a >= 112 && a < 116) exp_ctrl = w;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic access(input logic wr, input int a, input int code,
                        input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    check("R2 ready before request", 32'(host_ready), 32'd1);
    host_valid = 1'b1;
    host_write = wr;
    host_addr  = 7'(a);
    host_size  = 2'(code);
    host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    check("R2 not done one cycle after accept", 32'(host_done), 32'd0);
    check("R2 busy not ready", 32'(host_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R2 done two cycles after accept", 32'(host_done), 32'd1);
    rd = host_rdata;
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] ctrl_before;
    for (int i = 0; i < 16; i++) exp_core[i] = seed(i, 32'hA5C3_0F11);
    for (int i = 0; i < 8; i++)  exp_dma[i]  = seed(i, 32'h5A3C_F0EE);
    exp_ctrl = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ready", 32'(host_ready), 32'd1);
    check("R1 done", 32'(host_done), 32'd0);
    check("R1 ctrl", ctrl_q, 32'h0);
    rst_n = 1'b1;

    // Full sweep of offsets and size codes.
    for (int a = 0; a < 128; a++) begin
      for (int code = 0; code < 4; code++) begin
        logic [31:0] d;
        d = 32'h1357_9BDF ^ (32'(a) << 8) ^ (32'(code) * 32'h1111_0000);
        access(1'b1, a, code, d, rd);
        model_write(a, code, d);
        access(1'b0, a & ~3, 2, 32'h0, rd);
        check({tag_of(a), " R7 R8 R9 full word after write"}, rd, model_read(a & ~3, 2));
        access(1'b0, a, code, 32'h0, rd);
        check({tag_of(a), " R10 slice read"}, rd, model_read(a, code));
        if ((a % 4) != 0) begin
          // Next word must not see spilled lanes.
          access(1'b0, (a & ~3) + 4 < 128 ? (a & ~3) + 4 : 0, 2, 32'h0, rd);
          check("R9 next word untouched", rd,
                model_read((a & ~3) + 4 < 128 ? (a & ~3) + 4 : 0, 2));
        end
        @(negedge clk);
        check("R5 ctrl output", ctrl_q, exp_ctrl);
      end
    end

    // Reads leave the control register alone.
    ctrl_before = ctrl_q;
    access(1'b0, 113, 1, 32'hFFFF_FFFF, rd);
    check("R11 read slice ctrl", rd, model_read(113, 1));
    @(negedge clk);
    check("R11 ctrl unchanged by read", ctrl_q, ctrl_before);

    // Unmapped full write at an aligned offset right after the control word.
    access(1'b1, 116, 2, 32'hDEAD_BEEF, rd);
    access(1'b0, 116, 2, 32'h0, rd);
    check("R6 unmapped read zero", rd, 32'h0);
    @(negedge clk);
    check("R6 ctrl unchanged", ctrl_q, exp_ctrl);

    // Bench-side target contents must match the model.
    for (int i = 0; i < 16; i++) check("R3 core contents", core_mem[i], exp_core[i]);
    for (int i = 0; i < 8; i++)  check("R4 dma contents", dma_mem[i], exp_dma[i]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired got=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule